// File: doc/BRIEF.md
# Rectifying Knock-Energy Integrator with Hold Control

This block is a sampled digital model of the integrator stage in an engine knock detection chain. It takes a stream of signed samples from the band-pass filter at a fixed 200 kHz sample rate, marked by a valid strobe. It full-wave rectifies each sample and adds the scaled result to an energy accumulator. A 5-bit time-constant code sets how fast the accumulator grows. The accumulator is kept as two paths: a positive sum collects the energy of positive samples, and a negative sum, in opposite phase, collects the energy of negative samples. The output is the positive sum minus the negative sum, which is always the total rectified energy.

An integrate/hold input controls when the block integrates. A rising edge arms the block. After a fixed delay of four valid samples (20 µs at the sample rate), the output is forced to a small reset level, and accumulation starts from there. While the control input is low, the output stays frozen. The engine management controller reads the output at the end of each knock window.

Top module: `knock_integrator`

## Requirements
- R1: While `rst` is high at a clock edge, both paths are cleared, and `acc_out` is 0 after that edge.
- R2: During integration, each valid sample x adds |x|·g(code) to `acc_out`, where g(code) is the per-sample gain from R3. A sample with x ≥ 0 goes to the positive path and a sample with x < 0 goes to the negative path. In both cases the output rises by the same magnitude, and the new value is visible after the clock edge that takes the sample.
- R3: The time constant is tau = 40 + 18·code µs, for codes 0 to 31. The per-sample gain is g = floor((5·2^12 + floor(tau/2)) / tau), so `acc_out` carries 12 fractional bits relative to one input LSB. For example, code 0 gives g = 512 and code 31 gives g = 34.
- R4: At any clock edge where `int_hold` is low, `acc_out` does not change, whatever the sample inputs are.
- R5: A rising edge is a cycle where `int_hold` is 1 and was 0 at the previous clock edge; it arms the block. The sample in the rising-edge cycle is ignored. The next three valid samples are also ignored and leave `acc_out` unchanged. At the fourth valid sample, `acc_out` becomes the reset level 512 after that clock edge. Later valid samples accumulate as in R2.
- R6: At an edge where `smp_valid` is 0, `acc_out` does not change, in every phase.
- R7: `acc_out` saturates at 2^24−1 and never wraps around.
- R8: If `int_hold` falls while the block is armed but before the fourth valid sample, the reset level is not applied. The next rising edge restarts the count of four valid samples from zero.
- R9: The most negative sample, −32768, is rectified to a magnitude of 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks a new filtered sample on `smp_data` |
| smp_data | input | 16 | Signed filtered sample, two's complement |
| tc_code | input | 5 | Time-constant selection code |
| int_hold | input | 1 | 1 = integrate, 0 = hold; a rising edge arms the block |
| acc_out | output | 24 | Integrated energy: unsigned, 12 fractional bits |

## Verification
The assertions assume the inputs are sampled cleanly at the rising clock edge. They also assume that `int_hold` has been low or stable for a cycle after reset, so that its first high level counts as a rising edge. The arming checker counts valid samples since the last rising edge by itself, and the delay and freeze properties depend on that count. The stimulus changes all inputs only on the falling clock edge. It sweeps every time-constant code with a fixed mix of positive, negative, zero and full-scale samples. It also inserts idle cycles (valid low) inside the arming window and inside the integrating phase.

// File: rtl/kint_pkg.sv
package kint_pkg;

    localparam int TC_CODES    = 32;
    localparam int TC_BITS     = $clog2(TC_CODES);
    localparam int SAMPLE_US   = 5;
    localparam int TAU_BASE_US = 40;
    localparam int TAU_STEP_US = 18;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } kint_state_e;

    // Control word passed from the sequencer to the accumulator
    typedef struct packed {
        logic load;    // apply the reset level
        logic accum;   // add the current sample
        logic arming;  // inside the start-up delay window
    } kint_ctl_t;

    // Per-sample gain: sample period divided by tau, with frac_bits fractional bits, rounded
    function automatic int unsigned tc_gain(int unsigned code, int unsigned frac_bits);
        int unsigned tau;
        tau = TAU_BASE_US + TAU_STEP_US * code;
        return ((SAMPLE_US << frac_bits) + tau / 2) / tau;
    endfunction

endpackage

// File: rtl/kint_seq.sv
module kint_seq
    import kint_pkg::*;
#(
    parameter int DELAY = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      int_hold,
    input  logic      smp_valid,
    output kint_ctl_t ctl
);
    localparam int CW = $clog2(DELAY + 1);

    kint_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic          hold_q;
    logic          rise;
    logic          last_arm;

    always_comb begin
        rise       = int_hold & ~hold_q;
        last_arm   = (cnt_q == CW'(DELAY - 1));
        ctl.load   = (state_q == ST_ARM) && int_hold && !rise && smp_valid && last_arm;
        ctl.accum  = (state_q == ST_RUN) && int_hold && smp_valid;
        ctl.arming = (state_q == ST_ARM) && int_hold && !rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            hold_q  <= 1'b0;
        end else begin
            hold_q <= int_hold;
            if (!int_hold) begin
                state_q <= ST_HOLD;
            end else if (rise) begin
                state_q <= ST_ARM;
                cnt_q   <= '0;
            end else if (state_q == ST_ARM && smp_valid) begin
                if (last_arm) state_q <= ST_RUN;
                else          cnt_q   <= cnt_q + CW'(1);
            end
        end
    end

    // R5: load and accumulate are never requested in the same cycle
    ctl_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.load && ctl.accum));

endmodule

// File: rtl/kint_rect_gain.sv
module kint_rect_gain
    import kint_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 10,
    parameter int GF = 12,
    localparam int PW = DW + GW
) (
    input  logic signed [DW-1:0]      smp_data,
    input  logic        [TC_BITS-1:0] tc_code,
    output logic        [PW-1:0]      inc,
    output logic                      is_neg
);
    logic [GW-1:0] gain_rom [TC_CODES];

    // R3: gain table built from the time-constant formula
    for (genvar i = 0; i < TC_CODES; i++) begin : g_rom
        assign gain_rom[i] = GW'(tc_gain(i, GF));
    end

    logic [DW-1:0] raw;
    logic [DW-1:0] mag;
    logic [GW-1:0] gain;

    always_comb begin
        raw    = smp_data;
        is_neg = raw[DW-1];
        // R9: two's complement negation; the most negative value maps to 2^(DW-1)
        mag    = is_neg ? (~raw + DW'(1)) : raw;
        gain   = gain_rom[tc_code];
        inc    = PW'(mag) * PW'(gain);
    end

    // R3: the gain is never zero, so every nonzero sample adds energy
    gain_nz_chk: assert final (gain != '0);

endmodule

// File: rtl/kint_diff_acc.sv
module kint_diff_acc
    import kint_pkg::*;
#(
    parameter int AW          = 24,
    parameter int PW          = 26,
    parameter int RESET_LEVEL = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  kint_ctl_t     ctl,
    input  logic [PW-1:0] inc,
    input  logic          is_neg,
    output logic [AW-1:0] acc_out
);
    localparam int SW = ((AW > PW) ? AW : PW) + 2;
    localparam logic [AW-1:0]        MAXV      = '1;
    localparam logic signed [SW-1:0] POS_LIMIT = $signed(SW'(MAXV));
    localparam logic signed [SW-1:0] NEG_FLOOR = -POS_LIMIT;

    logic        [AW-1:0] pos_q;   // positive-half energy
    logic signed [AW:0]   neg_q;   // negative-half energy, opposite phase (<= 0)

    logic        [SW-1:0] pos_sum;
    logic        [AW-1:0] pos_nxt;
    logic signed [SW-1:0] neg_sum;
    logic signed [AW:0]   neg_nxt;
    logic signed [SW-1:0] diff;

    always_comb begin
        pos_sum = SW'(pos_q) + SW'(inc);
        pos_nxt = (pos_sum > SW'(MAXV)) ? MAXV : pos_sum[AW-1:0];
        neg_sum = SW'(neg_q) - $signed(SW'(inc));
        neg_nxt = (neg_sum < NEG_FLOOR) ? (AW+1)'(NEG_FLOOR) : neg_sum[AW:0];
        // R2: the output is the difference of the two paths
        diff    = $signed(SW'(pos_q)) - SW'(neg_q);
        // R7: clamp the combined value
        acc_out = (diff > POS_LIMIT) ? MAXV : diff[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            neg_q <= '0;
        end else if (ctl.load) begin
            pos_q <= AW'(RESET_LEVEL);
            neg_q <= '0;
        end else if (ctl.accum) begin
            if (is_neg) neg_q <= neg_nxt;
            else        pos_q <= pos_nxt;
        end
    end

    // R2
    acc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.accum |=> acc_out >= $past(acc_out));

    // R5
    reset_level_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> acc_out == AW'(RESET_LEVEL));

    // R5
    arm_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.arming && !ctl.load) |=> $stable(acc_out));

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.accum && acc_out == MAXV) |=> acc_out == MAXV);

endmodule

// File: rtl/knock_integrator.sv
module knock_integrator
    import kint_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 24,
    parameter int GW          = 10,
    parameter int GF          = 12,
    parameter int DELAY       = 4,
    parameter int RESET_LEVEL = 512
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic signed [DW-1:0]      smp_data,
    input  logic        [TC_BITS-1:0] tc_code,
    input  logic                      int_hold,
    output logic        [AW-1:0]      acc_out
);
    localparam int PW = DW + GW;
    localparam int CW = $clog2(DELAY + 1);

    kint_ctl_t     ctl;
    logic [PW-1:0] inc;
    logic          is_neg;

    kint_seq #(.DELAY(DELAY)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .int_hold  (int_hold),
        .smp_valid (smp_valid),
        .ctl       (ctl)
    );

    kint_rect_gain #(.DW(DW), .GW(GW), .GF(GF)) u_gain (
        .smp_data (smp_data),
        .tc_code  (tc_code),
        .inc      (inc),
        .is_neg   (is_neg)
    );

    kint_diff_acc #(.AW(AW), .PW(PW), .RESET_LEVEL(RESET_LEVEL)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .inc     (inc),
        .is_neg  (is_neg),
        .acc_out (acc_out)
    );

    // Independent count of valid samples since the last rising edge of int_hold
    logic          chk_hold_q;
    logic [CW-1:0] chk_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_hold_q <= 1'b0;
            chk_cnt_q  <= '0;
        end else begin
            chk_hold_q <= int_hold;
            if (int_hold && !chk_hold_q)
                chk_cnt_q <= '0;
            else if (int_hold && smp_valid && chk_cnt_q < CW'(DELAY))
                chk_cnt_q <= chk_cnt_q + CW'(1);
        end
    end

    // R5
    arm_delay_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.load |-> (chk_cnt_q == CW'(DELAY - 1)) && chk_hold_q);

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !int_hold |=> $stable(acc_out));

    // R6
    idle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(acc_out));

endmodule

// File: tb/test_knock_integrator.sv
`timescale 1ns/100ps
module test_knock_integrator;

    localparam longint MAXV = 64'd16777215;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic [4:0]         tc_code = '0;
    logic               int_hold = 1'b0;
    logic [23:0]        acc_out;

    int     n_chk  = 0;
    int     n_fail = 0;
    longint exp_v  = 0;

    always #2.5 clk = ~clk;

    knock_integrator i_knock_integrator (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .tc_code   (tc_code),
        .int_hold  (int_hold),
        .acc_out   (acc_out)
    );

    function automatic longint gain_of(int code);
        longint tau;
        tau = 40 + 18 * code;
        return (5 * 4096 + tau / 2) / tau;
    endfunction

    function automatic longint magn(int d);
        return (d < 0) ? -d : d;
    endfunction

    task automatic step(input logic h, input logic v, input int d);
        @(negedge clk);
        int_hold  = h;
        smp_valid = v;
        smp_data  = 16'(d);
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input longint expv);
        n_chk++;
        if (longint'(acc_out) != expv) begin
            n_fail++;
            $display("FAIL %s: acc_out=%0d expected=%0d", req, acc_out, expv);
        end
    endtask

    function automatic longint accum(longint cur, int d, int code);
        longint s;
        s = cur + magn(d) * gain_of(code);
        return (s > MAXV) ? MAXV : s;
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: acc_out=%0d expected=finished", acc_out);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int data_set [6] = '{100, -200, 0, 12345, -32768, 32767};
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", 0);
        @(negedge clk);
        rst = 1'b0;

        for (int code = 0; code < 32; code++) begin
            @(negedge clk);
            tc_code = 5'(code);
            step(0, 1, 1234);     chk("R4 hold ignores sample", exp_v);
            step(1, 1, 500);      chk("R5 rise sample ignored", exp_v);
            step(1, 1, 700);      chk("R5 arm sample 1", exp_v);
            step(1, 0, 9999);     chk("R6 idle during arm", exp_v);
            step(1, 1, -300);     chk("R5 arm sample 2", exp_v);
            step(1, 1, 42);       chk("R5 arm sample 3", exp_v);
            step(1, 1, 77);       exp_v = 512; chk("R5 reset level", exp_v);
            for (int k = 0; k < 6; k++) begin
                step(1, 1, data_set[k]);
                exp_v = accum(exp_v, data_set[k], code);
                if (data_set[k] == -32768)   chk("R9 full-scale negative", exp_v);
                else if (exp_v == MAXV)      chk("R7 saturation", exp_v);
                else                         chk("R2 R3 accumulate", exp_v);
            end
            step(1, 0, -5000);    chk("R6 idle during run", exp_v);
        end

        // R8: abort during arming, then restart the count
        @(negedge clk);
        tc_code = 5'd5;
        step(0, 0, 0);        chk("R4 hold", exp_v);
        step(1, 1, 10);       chk("R8 rise", exp_v);
        step(1, 1, 10);       chk("R8 arm 1", exp_v);
        step(1, 1, 10);       chk("R8 arm 2", exp_v);
        step(0, 1, 10);       chk("R8 abort", exp_v);
        step(0, 1, 10);       chk("R8 aborted hold", exp_v);
        step(1, 1, 10);       chk("R8 re-rise", exp_v);
        step(1, 1, 10);       chk("R8 recount 1", exp_v);
        step(1, 1, 10);       chk("R8 recount 2", exp_v);
        step(1, 1, 10);       chk("R8 recount 3", exp_v);
        step(1, 1, 10);       exp_v = 512; chk("R8 reset after recount", exp_v);
        step(1, 1, -1000);    exp_v = accum(exp_v, -1000, 5); chk("R2 negative path", exp_v);
        step(0, 1, 30000);    chk("R4 hold after run", exp_v);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule